// File: doc/BRIEF.md
# Dual-Lane Framed Serial DAC Code Loader

This block receives two serial bit streams, one for the in-phase DAC and one for the quadrature DAC, and turns them into two parallel DAC code registers. Both lanes are sampled on the rising edge of the master clock and share one frame strobe. The strobe is high for one cycle just before the most significant bit of a pair of 16-bit words. The loader keeps the first 10 bits of each word as the DAC code and drops the 6 trailing bits.

Words are expected back to back, so each frame strobe coincides with the last bit of the previous word. Both code registers take their new values on the same clock edge, once every 16 cycles, and a one-cycle strobe marks each load. If the strobe is missing where the next word should begin, the loader flags an error, keeps the codes it has, and waits for a new strobe. The loader only runs while the analog mode select is high. In the other modes the same pins carry different signals and the receiver stays idle.

Top module: `dac_pair_loader`

## Requirements
- R1: A synchronous active-low reset clears both codes to zero and drives the update strobe and the error flag low. After reset the receiver waits for a frame strobe.
- R2: While the receiver waits, a frame strobe sampled high starts a word. The next 16 rising edges sample one bit per lane, most significant bit first.
- R3: Each code is the first 10 bits received, so the first bit lands in code bit 9. The last 6 bits of the word have no effect on either code.
- R4: Both codes load together on the edge that samples the 16th bit, and the new values show in the following cycle. A frame strobe sampled with that 16th bit starts the next word at once, which gives one load every 16 cycles.
- R5: The update strobe is high for exactly one cycle with each load and low in every other cycle.
- R6: If the frame strobe is low when the 16th bit is sampled, the word still loads and the error flag goes high. The receiver then waits and the codes hold. The flag clears when a frame strobe is accepted.
- R7: While the analog mode select is low, the receiver is idle. A partial word is discarded, frame strobes and data are ignored, and no load occurs.
- R8: A frame strobe sampled at any bit position other than the 16th, while a word is in progress, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| analog_mode_i | input | 1 | High enables the loader; low holds it idle |
| frame_i | input | 1 | Frame strobe, high one cycle before the MSB |
| i_data_i | input | 1 | In-phase serial data lane |
| q_data_i | input | 1 | Quadrature serial data lane |
| i_code_o | output | 10 | In-phase DAC code |
| q_code_o | output | 10 | Quadrature DAC code |
| update_o | output | 1 | One-cycle strobe marking a code load |
| frame_err_o | output | 1 | Set when an expected frame strobe is missing |

## Verification
The assertions assume the inputs change only between rising edges and hold steady across them. They also assume the reset is held for at least two cycles, so the first comparison with an earlier sample sees cleared codes. The bench drives every input on the falling edge, holds reset for several cycles, and checks outputs on the falling edge that follows each sampling edge. Every stream it sends starts with a frame strobe. Missing, misplaced and mode-gated strobes are produced on purpose to exercise the error and idle paths.

// File: rtl/dac_ldr_pkg.sv
// Package: shared types for the dual-lane DAC code loader.
// Assumes: nothing beyond being compiled before the loader modules.
package dac_ldr_pkg;

    // Receiver phase: waiting for a frame strobe, or inside a word.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_t;

    // Number of serial lanes loaded in lockstep (in-phase and quadrature).
    localparam int LANES = 2;

endpackage

// File: rtl/dac_ldr_frame_tracker.sv
// Module: frame tracker. It follows the frame strobe, counts bit positions
// within a word, tells the lanes when to shift, marks the last bit and keeps
// the missing-frame error flag.
// Assumes: CODE_BITS < WORD_BITS. frame_i is sampled with the same edge as data.
module dac_ldr_frame_tracker
    import dac_ldr_pkg::*;
#(
    parameter int WORD_BITS = 16,
    parameter int CODE_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic frame_i,
    output logic sample_en_o,
    output logic word_end_o,
    output logic frame_err_o
);

    localparam int IDX_W = $clog2(WORD_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BITS - 1);
    localparam logic [IDX_W-1:0] KEEP_LIM = IDX_W'(CODE_BITS);

    rx_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             err_q;
    logic             running;

    // Receiver is inside a word and the mode allows it to work.
    assign running     = (state_q == ST_RUN) && enable_i;
    assign sample_en_o = running && (idx_q < KEEP_LIM);
    assign word_end_o  = running && (idx_q == LAST_IDX);
    assign frame_err_o = err_q;

    // Phase, bit position and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else if (!enable_i) begin
            state_q <= ST_WAIT;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (frame_i) begin
                        state_q <= ST_RUN;
                        idx_q   <= '0;
                        err_q   <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (idx_q == LAST_IDX) begin
                        idx_q <= '0;
                        if (!frame_i) begin
                            state_q <= ST_WAIT;
                            err_q   <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/dac_ldr_lane_shift.sv
// Module: one lane shifter. It collects the leading CODE_BITS bits of a word,
// MSB first, while the tracker enables shifting.
// Assumes: shift_en_i is high for exactly CODE_BITS cycles per full word.
module dac_ldr_lane_shift #(
    parameter int CODE_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en_i,
    input  logic                 bit_i,
    output logic [CODE_BITS-1:0] code_o
);

    logic [CODE_BITS-1:0] sr_q;

    // Shift left, the newest bit entering at the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en_i) begin
            sr_q <= {sr_q[CODE_BITS-2:0], bit_i};
        end
    end

    assign code_o = sr_q;

endmodule

// File: rtl/dac_pair_loader.sv
// Module: dual-lane framed serial DAC code loader (top). Two lanes share one
// frame strobe. Both codes load together at the end of every word.
// Assumes: analog_mode_i selects this loader. Inputs are stable around the
// rising edge of clk.
module dac_pair_loader
    import dac_ldr_pkg::*;
#(
    parameter int WORD_BITS = 16,
    parameter int CODE_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 analog_mode_i,
    input  logic                 frame_i,
    input  logic                 i_data_i,
    input  logic                 q_data_i,
    output logic [CODE_BITS-1:0] i_code_o,
    output logic [CODE_BITS-1:0] q_code_o,
    output logic                 update_o,
    output logic                 frame_err_o
);

    logic                 sample_en;
    logic                 word_end;
    logic [LANES-1:0]     lane_bit;
    logic [CODE_BITS-1:0] lane_shift [LANES];
    logic [CODE_BITS-1:0] lane_code  [LANES];
    logic                 update_q;

    assign lane_bit = {q_data_i, i_data_i};

    dac_ldr_frame_tracker #(
        .WORD_BITS (WORD_BITS),
        .CODE_BITS (CODE_BITS)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (analog_mode_i),
        .frame_i     (frame_i),
        .sample_en_o (sample_en),
        .word_end_o  (word_end),
        .frame_err_o (frame_err_o)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        dac_ldr_lane_shift #(
            .CODE_BITS (CODE_BITS)
        ) u_shift (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_en_i (sample_en),
            .bit_i      (lane_bit[ln]),
            .code_o     (lane_shift[ln])
        );

        // Output code register for this lane, loaded at word end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_code[ln] <= '0;
            end else if (word_end) begin
                lane_code[ln] <= lane_shift[ln];
            end
        end
    end

    // One-cycle load strobe, aligned with the new codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            update_q <= 1'b0;
        end else begin
            update_q <= word_end;
        end
    end

    assign i_code_o = lane_code[0];
    assign q_code_o = lane_code[1];
    assign update_o = update_q;

endmodule

// File: rtl/dac_pair_loader_checker.sv
// Module: assertion checker for the loader, attached by bind. It watches only
// the ports of the top module.
// Assumes: reset is held low for at least two cycles at start-up.
module dac_pair_loader_checker #(
    parameter int WORD_BITS = 16,
    parameter int CODE_BITS = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 analog_mode_i,
    input logic                 frame_i,
    input logic [CODE_BITS-1:0] i_code_o,
    input logic [CODE_BITS-1:0] q_code_o,
    input logic                 update_o,
    input logic                 frame_err_o
);

    localparam int GAP_W = $clog2(WORD_BITS) + 2;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(WORD_BITS - 1);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the last load, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (update_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o); // R5

    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !update_o |-> ($stable(i_code_o) && $stable(q_code_o))); // R5

    AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (update_o && seen_q) |-> (gap_q >= GAP_MIN)); // R4

    AST_ERR_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> update_o); // R6

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !analog_mode_i |=> !update_o); // R7

    AST_ERR_CLEAR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err_o) |-> $past(frame_i && analog_mode_i)); // R6

endmodule

bind dac_pair_loader dac_pair_loader_checker #(
    .WORD_BITS (WORD_BITS),
    .CODE_BITS (CODE_BITS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .analog_mode_i (analog_mode_i),
    .frame_i       (frame_i),
    .i_code_o      (i_code_o),
    .q_code_o      (q_code_o),
    .update_o      (update_o),
    .frame_err_o   (frame_err_o)
);

// File: tb/dac_pair_loader_test.sv
module dac_pair_loader_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       analog_mode_i;
    logic       frame_i;
    logic       i_data_i;
    logic       q_data_i;
    logic [9:0] i_code_o;
    logic [9:0] q_code_o;
    logic       update_o;
    logic       frame_err_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_pair_loader uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .analog_mode_i (analog_mode_i),
        .frame_i       (frame_i),
        .i_data_i      (i_data_i),
        .q_data_i      (q_data_i),
        .i_code_o      (i_code_o),
        .q_code_o      (q_code_o),
        .update_o      (update_o),
        .frame_err_o   (frame_err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs now (falling edge), return at the next falling edge.
    task automatic step(input logic f, input logic di, input logic dq);
        frame_i  = f;
        i_data_i = di;
        q_data_i = dq;
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int w, input int seed, input bit lane_q);
        logic [15:0] x;
        if (seed == 99) begin
            if (w == 0) x = lane_q ? 16'hFFC0 : 16'h003F;
            else        x = lane_q ? 16'h0000 : 16'hFFFF;
        end else begin
            x = 16'(seed * 947 + w * 40503) ^ 16'h5A5A;
            if (lane_q) x = ~{x[6:0], x[15:7]};
        end
        return x;
    endfunction

    // Continuous burst, closing without a frame strobe (sets the error flag).
    task automatic run_burst(input int nwords, input int seed, input int extra_at);
        logic [9:0] last_i, last_q;
        step(1'b1, 1'b0, 1'b0);
        chk(frame_err_o == 1'b0, "R6 error cleared by accepted frame", 16'(frame_err_o), 16'h0);
        for (int w = 0; w < nwords; w++) begin
            logic [15:0] iw, qw;
            iw = pat(w, seed, 1'b0);
            qw = pat(w, seed, 1'b1);
            for (int b = 0; b < 16; b++) begin
                logic f;
                f = (b == 15 && w < nwords - 1) || (w == 1 && b == extra_at);
                step(f, iw[15-b], qw[15-b]);
                if (b == 14)
                    chk(update_o == 1'b0, "R5 no strobe before word end", 16'(update_o), 16'h0);
                if (b == 15) begin
                    chk(update_o == 1'b1, "R4 strobe after 16th bit", 16'(update_o), 16'h1);
                    chk(i_code_o == iw[15:6], "R3 R2 I code from leading bits", 16'(i_code_o), 16'(iw[15:6]));
                    chk(q_code_o == qw[15:6], "R3 R2 Q code from leading bits", 16'(q_code_o), 16'(qw[15:6]));
                end
            end
        end
        chk(frame_err_o == 1'b1, "R6 error on missing frame", 16'(frame_err_o), 16'h1);
        last_i = i_code_o;
        last_q = q_code_o;
        for (int k = 0; k < 20; k++) begin
            step(1'b0, k[0], k[1]);
            chk(update_o == 1'b0 && i_code_o == last_i && q_code_o == last_q,
                "R6 codes hold after error", {i_code_o[7:0], q_code_o[7:0]},
                {last_i[7:0], last_q[7:0]});
        end
    endtask

    task automatic test_reset();
        chk(i_code_o == 10'h0 && q_code_o == 10'h0, "R1 reset codes", {6'h0, i_code_o}, 16'h0);
        chk(update_o == 1'b0 && frame_err_o == 1'b0, "R1 reset flags",
            {14'h0, update_o, frame_err_o}, 16'h0);
        for (int k = 0; k < 20; k++) step(1'b0, 1'b1, 1'b1);
        chk(update_o == 1'b0 && i_code_o == 10'h0, "R1 waits for frame", {6'h0, i_code_o}, 16'h0);
    endtask

    task automatic test_mode_idle();
        logic [9:0] hi, hq;
        hi = i_code_o;
        hq = q_code_o;
        step(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, 1'b0);
        analog_mode_i = 1'b0;
        for (int k = 0; k < 40; k++) begin
            step((k % 16) == 0, 1'b1, 1'b1);
            chk(update_o == 1'b0 && i_code_o == hi && q_code_o == hq, "R7 idle while mode low",
                {i_code_o[7:0], q_code_o[7:0]}, {hi[7:0], hq[7:0]});
        end
        analog_mode_i = 1'b1;
        for (int k = 0; k < 20; k++) begin
            step(1'b0, 1'b1, 1'b1);
            chk(update_o == 1'b0 && i_code_o == hi, "R7 partial word discarded",
                {15'h0, update_o}, 16'h0);
        end
    endtask

    task automatic test_mid_reset();
        step(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b1);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        chk(i_code_o == 10'h0 && q_code_o == 10'h0 && frame_err_o == 1'b0,
            "R1 reset mid-word", {i_code_o[7:0], q_code_o[7:0]}, 16'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) step(1'b0, 1'b1, 1'b1);
        chk(update_o == 1'b0 && i_code_o == 10'h0, "R1 no load without frame after reset",
            {6'h0, i_code_o}, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        analog_mode_i = 1'b1;
        frame_i = 1'b0;
        i_data_i = 1'b0;
        q_data_i = 1'b0;
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_reset();
        run_burst(4, 1, -1);
        run_burst(2, 99, -1);
        run_burst(3, 7, 5);       // R8: stray frame strobe at bit 5 of word 1
        run_burst(3, 12, 0);      // R8: stray frame strobe at the MSB of word 1
        test_mode_idle();
        run_burst(2, 3, -1);
        test_mid_reset();
        run_burst(5, 21, 9);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule